// File: doc/BRIEF.md
# Pointer-Started Single-Channel DMA Engine

This block moves a run of words from a peripheral into memory without help from the processor. Software places a three-word command block in memory and gives the engine only that block's address with a one-cycle start pulse. The engine then reads the command block over the shared memory bus. The first word is the device-side source address, the second is the memory destination address and the third is a byte count.

Each word is paced by the device. The device raises a request when it holds a word. The engine asks the bus arbiter for the memory bus, drives the destination address and the device's data, and acknowledges the device in the granted cycle. It then lets go of the bus at once, so the processor loses only that one cycle. When the last word has been written, a level interrupt rises and stays high until software clears it. A busy output tells software whether a new start will be taken.

Top module: `dma_engine`

## Requirements
- R1: After an accepted start, the engine makes exactly three bus reads (`bus_we`=0) at `cmd_ptr`, `cmd_ptr`+4 and `cmd_ptr`+8, in that order, before any data write. The three words are taken as source, destination and byte count.
- R2: `bus_req` stays high until `bus_gnt` is seen. Each access occurs in the cycle where both are high, and `bus_req` is low in the following cycle.
- R3: A data word moves only in a cycle with `dev_dreq` high, `bus_req` and `bus_gnt` high. In that cycle `bus_we`=1, `bus_wdata`=`dev_data` and `dev_dack`=1. `dev_dack` is never high otherwise.
- R4: The k-th word (from 0) is written at destination+4k, and `dev_addr` is source+4k while it is acknowledged.
- R5: The number of words written equals the byte count divided by 4, rounded up.
- R6: A byte count of zero makes no data write and no acknowledge. With an always-granting bus, `irq` is high 6 clock edges after the edge that took the start.
- R7: `irq` rises on the edge that completes the last word. It then holds until a cycle with `irq_clr`=1, after which it is low.
- R8: `busy` is high from the edge after an accepted start until the edge that raises `irq`. A start while `busy` is high is ignored. `bus_req` is never high while idle.
- R9: After reset, `busy`, `irq`, `bus_req` and `dev_dack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle start pulse, taken only when idle |
| cmd_ptr | input | AW | Memory address of the command block |
| irq_clr | input | 1 | Clears the completion interrupt |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Completion interrupt, level |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| bus_addr | output | AW | Memory bus address |
| bus_we | output | 1 | Memory bus write enable |
| bus_wdata | output | DW | Memory bus write data |
| bus_rdata | input | DW | Memory bus read data, valid in the granted cycle |
| dev_dreq | input | 1 | Device has a word ready |
| dev_dack | output | 1 | Word taken by the engine |
| dev_addr | output | AW | Current device-side source address |
| dev_data | input | DW | Word offered by the device |

## Verification
The command-block reads are granted on the first, third and fifth edges after the start edge. With a zero count, the interrupt is visible at the seventh falling edge after start is raised, and the bench counts falling edges to that point exactly. A data word needs one edge from request to bus request and one more for the granted write. The device re-raises its request one edge after the acknowledge, so each word takes three cycles; the bench logs every granted access at the edge and compares the logs after the interrupt. Clearing is checked at the falling edge after the clear pulse. The ignored start is checked through the bus read log while the engine is stalled.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_GAP,
    S_WAIT,
    S_MOVE
  } dma_state_e;

  localparam int unsigned WORD_BYTES = 4;
  localparam int unsigned DESC_WORDS = 3;
endpackage

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       irq_clr,
  input  logic       bus_gnt,
  input  logic       dev_dreq,
  input  logic       cnt_zero,
  input  logic       last_word,
  output dma_state_e state,
  output logic [1:0] fld_idx,
  output logic       load_base,
  output logic       desc_we,
  output logic       word_done,
  output logic       irq,
  output logic       busy
);
  localparam logic [1:0] IDX_END = 2'(DESC_WORDS);

  logic desc_done;
  logic irq_set;

  assign load_base = (state == S_IDLE) && start;
  assign desc_we   = (state == S_FETCH) && bus_gnt;
  assign word_done = (state == S_MOVE) && bus_gnt;
  assign desc_done = (state == S_GAP) && (fld_idx == IDX_END);
  assign irq_set   = (desc_done && cnt_zero) || (word_done && last_word);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (start) state <= S_FETCH;
        S_FETCH: if (bus_gnt) state <= S_GAP;
        S_GAP: begin
          if (fld_idx == IDX_END) state <= cnt_zero ? S_IDLE : S_WAIT;
          else                    state <= S_FETCH;
        end
        S_WAIT:  if (dev_dreq) state <= S_MOVE;
        S_MOVE:  if (bus_gnt) state <= last_word ? S_IDLE : S_WAIT;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fld_idx <= '0;
    else if (load_base) fld_idx <= '0;
    else if (desc_we)   fld_idx <= fld_idx + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       irq <= 1'b0;
    else if (irq_set) irq <= 1'b1;
    else if (irq_clr) irq <= 1'b0;
  end
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_base,
  input  logic [AW-1:0] base_ptr,
  input  logic          desc_we,
  input  logic [1:0]    fld_idx,
  input  logic [DW-1:0] rdata,
  input  logic          word_done,
  output logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          cnt_zero,
  output logic          last_word
);
  localparam int CW = DW - 1;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return a + AW'(WORD_BYTES);
  endfunction

  function automatic logic [CW-1:0] words_for(input logic [DW-1:0] nbytes);
    return CW'(nbytes[DW-1:2]) + CW'(|nbytes[1:0]);
  endfunction

  logic [AW-1:0] base_q;
  logic [CW-1:0] words_q;

  assign fetch_addr = base_q + AW'({fld_idx, 2'b00});
  assign cnt_zero   = (words_q == '0);
  assign last_word  = (words_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      src_addr <= '0;
      dst_addr <= '0;
      words_q  <= '0;
    end else begin
      if (load_base) base_q <= base_ptr;
      if (desc_we) begin
        case (fld_idx)
          2'd0:    src_addr <= AW'(rdata);
          2'd1:    dst_addr <= AW'(rdata);
          default: words_q  <= words_for(rdata);
        endcase
      end else if (word_done) begin
        src_addr <= next_addr(src_addr);
        dst_addr <= next_addr(dst_addr);
        words_q  <= words_q - CW'(1);
      end
    end
  end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cmd_ptr,
  input  logic          irq_clr,
  output logic          busy,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [AW-1:0] bus_addr,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          dev_dreq,
  output logic          dev_dack,
  output logic [AW-1:0] dev_addr,
  input  logic [DW-1:0] dev_data
);
  dma_state_e    state;
  logic [1:0]    fld_idx;
  logic          load_base;
  logic          desc_we;
  logic          word_done;
  logic          cnt_zero;
  logic          last_word;
  logic [AW-1:0] fetch_addr;
  logic [AW-1:0] src_addr;
  logic [AW-1:0] dst_addr;

  dma_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .irq_clr   (irq_clr),
    .bus_gnt   (bus_gnt),
    .dev_dreq  (dev_dreq),
    .cnt_zero  (cnt_zero),
    .last_word (last_word),
    .state     (state),
    .fld_idx   (fld_idx),
    .load_base (load_base),
    .desc_we   (desc_we),
    .word_done (word_done),
    .irq       (irq),
    .busy      (busy)
  );

  dma_xfer_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_base  (load_base),
    .base_ptr   (cmd_ptr),
    .desc_we    (desc_we),
    .fld_idx    (fld_idx),
    .rdata      (bus_rdata),
    .word_done  (word_done),
    .fetch_addr (fetch_addr),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .cnt_zero   (cnt_zero),
    .last_word  (last_word)
  );

  assign bus_req   = (state == S_FETCH) || (state == S_MOVE);
  assign bus_we    = (state == S_MOVE);
  assign bus_addr  = (state == S_FETCH) ? fetch_addr : dst_addr;
  assign bus_wdata = dev_data;
  assign dev_dack  = word_done;
  assign dev_addr  = src_addr;
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          irq,
  input logic          irq_clr,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_we,
  input logic          dev_dreq,
  input logic          dev_dack,
  input logic          word_done,
  input logic [AW-1:0] dst_addr
);
  AST_DACK_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    dev_dack |-> (bus_req && bus_gnt && bus_we)); // R3
  AST_DACK_DREQ: assert property (@(posedge clk) disable iff (!rst_n)
    dev_dack |-> dev_dreq); // R3
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> !bus_req); // R2
  AST_DST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (dst_addr == $past(dst_addr) + AW'(4))); // R4
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R7
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy)); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R8
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req); // R8
endmodule

bind dma_engine dma_engine_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .irq       (irq),
  .irq_clr   (irq_clr),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_we    (bus_we),
  .dev_dreq  (dev_dreq),
  .dev_dack  (dev_dack),
  .word_done (word_done),
  .dst_addr  (dst_addr)
);

// File: tb/test_dma_engine.sv
module test_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cmd_ptr = '0;
  logic        irq_clr = 1'b0;
  logic        busy, irq, bus_req, bus_gnt, bus_we, dev_dack;
  logic [31:0] bus_addr, bus_wdata, bus_rdata, dev_addr, dev_data;
  logic        dev_dreq = 1'b0;
  logic        gnt_en = 1'b1;
  logic        dev_auto = 1'b1;

  logic [31:0] dmem [0:255];
  int n_chk = 0, n_pass = 0;
  int rd_n = 0, wr_n = 0, ack_n = 0, seq = 0, r2_bad = 0;
  logic prev_acc = 1'b0;
  logic [31:0] rd_log [0:63];
  logic [31:0] wr_a [0:255];
  logic [31:0] wr_d [0:255];
  logic [31:0] ack_a [0:255];

  always #4 clk = ~clk;

  assign bus_gnt   = bus_req & gnt_en;
  assign bus_rdata = dmem[bus_addr[9:2]];
  assign dev_data  = 32'hD000_0000 + 32'(seq);

  dma_engine i_dma_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_ptr(cmd_ptr),
    .irq_clr(irq_clr), .busy(busy), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_dreq(dev_dreq), .dev_dack(dev_dack), .dev_addr(dev_addr),
    .dev_data(dev_data)
  );

  // bus and device models with access logs
  always @(posedge clk) begin
    if (bus_req && bus_gnt && !bus_we) begin
      if (rd_n < 64) rd_log[rd_n] <= bus_addr;
      rd_n <= rd_n + 1;
    end
    if (bus_req && bus_gnt && bus_we) begin
      if (wr_n < 256) begin
        wr_a[wr_n] <= bus_addr;
        wr_d[wr_n] <= bus_wdata;
      end
      wr_n <= wr_n + 1;
    end
    if (dev_dack) begin
      if (ack_n < 256) ack_a[ack_n] <= dev_addr;
      ack_n    <= ack_n + 1;
      seq      <= seq + 1;
      dev_dreq <= 1'b0;
    end else begin
      dev_dreq <= dev_auto;
    end
    if (prev_acc && bus_req) r2_bad <= r2_bad + 1;
    prev_acc <= bus_req && bus_gnt;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=0x%h expected=0x%h", req, act, exp);
  endtask

  function automatic int exp_words(input int unsigned nbytes);
    int w = nbytes / 4;
    if (nbytes % 4 != 0) w = w + 1;
    return w;
  endfunction

  task automatic set_desc(input logic [31:0] p, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] n);
    dmem[p[9:2]]       = s;
    dmem[p[9:2] + 8'd1] = d;
    dmem[p[9:2] + 8'd2] = n;
  endtask

  task automatic pulse_start(input logic [31:0] p);
    @(negedge clk);
    cmd_ptr = p;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
  endtask

  task automatic wait_irq();
    int cyc = 0;
    while (!irq && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic clear_irq();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy, "R9 busy", 32'(busy), 0);
    check(!irq, "R9 irq", 32'(irq), 0);
    check(!bus_req, "R9 bus_req", 32'(bus_req), 0);
    check(!dev_dack, "R9 dev_dack", 32'(dev_dack), 0);
  endtask

  task automatic t_xfer(input logic [31:0] p, input logic [31:0] s,
                        input logic [31:0] d, input int unsigned nbytes);
    int rd0 = rd_n, wr0 = wr_n, ak0 = ack_n, sq0 = seq;
    int w = exp_words(nbytes);
    set_desc(p, s, d, nbytes);
    pulse_start(p);
    wait_irq();
    check(irq, "R7 irq after transfer", 32'(irq), 1);
    check(!busy, "R8 busy low at irq", 32'(busy), 0);
    check(rd_n - rd0 == 3, "R1 read count", 32'(rd_n - rd0), 3);
    for (int k = 0; k < 3; k++)
      check(rd_log[rd0 + k] == p + 32'(4 * k), "R1 read order",
            rd_log[rd0 + k], p + 32'(4 * k));
    check(wr_n - wr0 == w, "R5 word count", 32'(wr_n - wr0), 32'(w));
    check(ack_n - ak0 == w, "R3 ack count", 32'(ack_n - ak0), 32'(w));
    for (int i = 0; i < w; i++) begin
      check(wr_a[wr0 + i] == d + 32'(4 * i), "R4 dst address",
            wr_a[wr0 + i], d + 32'(4 * i));
      check(wr_d[wr0 + i] == 32'hD000_0000 + 32'(sq0 + i), "R3 data",
            wr_d[wr0 + i], 32'hD000_0000 + 32'(sq0 + i));
      check(ack_a[ak0 + i] == s + 32'(4 * i), "R4 src address",
            ack_a[ak0 + i], s + 32'(4 * i));
    end
    repeat (4) @(negedge clk);
    check(irq, "R7 irq holds", 32'(irq), 1);
    clear_irq();
    check(!irq, "R7 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_zero();
    int wr0 = wr_n, ak0 = ack_n, cyc = 0;
    set_desc(32'h180, 32'h8000_1000, 32'h3C0, 32'd0);
    @(negedge clk);
    cmd_ptr = 32'h180;
    start   = 1'b1;
    while (!irq && cyc < 100) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check(cyc == 7, "R6 zero-count irq timing", 32'(cyc), 7);
    check(wr_n == wr0, "R6 no data write", 32'(wr_n - wr0), 0);
    check(ack_n == ak0, "R6 no acknowledge", 32'(ack_n - ak0), 0);
    clear_irq();
  endtask

  task automatic t_busy_start();
    int rd0 = rd_n, wr0 = wr_n;
    dev_auto = 1'b0;
    set_desc(32'h1C0, 32'h8000_2000, 32'h240, 32'd8);
    set_desc(32'h1E0, 32'h8000_3000, 32'h2C0, 32'd12);
    pulse_start(32'h1C0);
    repeat (10) @(negedge clk);
    check(busy, "R8 busy while stalled", 32'(busy), 1);
    pulse_start(32'h1E0);
    repeat (3) @(negedge clk);
    check(rd_n - rd0 == 3, "R8 start while busy ignored", 32'(rd_n - rd0), 3);
    check(wr_n == wr0, "R3 no write without dreq", 32'(wr_n - wr0), 0);
    dev_auto = 1'b1;
    wait_irq();
    check(wr_n - wr0 == 2, "R8 original transfer kept", 32'(wr_n - wr0), 2);
    check(wr_a[wr0] == 32'h240, "R8 original destination", wr_a[wr0], 32'h240);
    clear_irq();
  endtask

  task automatic t_grant_wait();
    int rd0 = rd_n, wr0 = wr_n;
    set_desc(32'h200, 32'h8000_4000, 32'h380, 32'd6);
    @(negedge clk);
    gnt_en = 1'b0;
    pulse_start(32'h200);
    repeat (12) @(negedge clk);
    check(bus_req, "R2 request held", 32'(bus_req), 1);
    check(rd_n == rd0, "R2 no access without grant", 32'(rd_n - rd0), 0);
    gnt_en = 1'b1;
    wait_irq();
    check(wr_n - wr0 == 2, "R5 six bytes give two words", 32'(wr_n - wr0), 2);
    check(r2_bad == 0, "R2 request released after access", 32'(r2_bad), 0);
    clear_irq();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_xfer(32'h100, 32'h8000_0040, 32'h200, 16);
    t_xfer(32'h140, 32'h9000_0000, 32'h300, 10);
    t_xfer(32'h160, 32'h9000_0100, 32'h3A0, 1);
    t_zero();
    t_busy_start();
    t_grant_wait();
    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_pass, n_chk + 1);
    $finish;
  end
endmodule